// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block is the shift engine of a byte-wide SPI master. Once a start strobe arrives with the bus enabled, it runs one burst of a programmed number of byte exchanges. For each byte it takes a transmit byte from an external TX FIFO, shifts the byte out on MOSI while it samples MISO, and then hands the received byte to an external RX FIFO. The FIFOs, the SCK rate divider and the interrupt logic sit outside the block. The divider supplies a one-cycle tick for each SCK half period.

A control word selects the clock polarity and phase, the bit order, whether received bytes are kept or discarded, and the chip select behaviour. The chip select can follow the burst automatically or be held at a programmed level. The burst count sets the total number of bytes exchanged. The transmit count sets how many of those bytes come from the TX FIFO. The rest of the burst is sent as zero filler. At the end of a burst the block emits a one-cycle completion pulse and drops its busy flag. Software reads the busy flag back as the start bit.

Top module: `spi_xfer_seq`

## Requirements
- R1: A start strobe seen while idle with the bus enabled raises busy_o on the next cycle. busy_o stays high for the whole burst and falls in the cycle after the completion pulse.
- R2: In ctrl_i, bit 1 is the SCK idle level (CPOL) and bit 0 is the phase (CPHA). With CPHA=0 the slave samples MOSI and the master samples MISO on the leading SCK edge of each bit. With CPHA=1 both sample on the trailing edge. Each byte takes exactly 16 SCK transitions, and SCK ends each byte at its idle level.
- R3: ctrl_i bit 12 set shifts each byte least-significant bit first, both on MOSI and when MISO bits are assembled into the received byte. Clear means most-significant bit first.
- R4: A burst exchanges burst_cnt_i bytes (24-bit counts). The first min(xmit_cnt_i, burst_cnt_i) bytes are popped from the TX FIFO, and every later byte is sent as 0x00 without a pop. Without discard, every exchanged byte is pushed to the RX FIFO, in order.
- R5: While ctrl_i bit 8 is set at start, no received byte is pushed to the RX FIFO. MOSI traffic is unchanged.
- R6: Chip select lines idle at the level given by ctrl_i bit 2. The line picked by ctrl_i[5:4] is driven to the opposite level while busy, in automatic mode. The other lines always stay inactive.
- R7: With ctrl_i bit 6 set, the selected chip select line is driven to the level in ctrl_i bit 7, whether or not a burst is running.
- R8: If the TX FIFO is empty while transmit bytes are still due, the engine waits without popping, and SCK stays at its idle level until data arrives.
- R9: done_o is a single-cycle pulse. It comes after the last byte's final sample and after that byte's RX push.
- R10: While bus_en_i is low, sclk_o is held low and a start strobe is ignored.
- R11: A burst count of zero completes with a done pulse, with no SCK transitions and no FIFO traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_i | input | 13 | Control word (mode, bit order, discard, chip select fields) |
| start_i | input | 1 | Start strobe (write of the start bit) |
| bus_en_i | input | 1 | Global bus enable |
| burst_cnt_i | input | 24 | Bytes in the burst |
| xmit_cnt_i | input | 24 | Bytes taken from the TX FIFO |
| sck_tick_i | input | 1 | Half-period tick from the SCK divider |
| tx_empty_i | input | 1 | TX FIFO empty |
| tx_data_i | input | 8 | TX FIFO head byte |
| tx_pop_o | output | 1 | TX FIFO pop |
| rx_push_o | output | 1 | RX FIFO push |
| rx_data_o | output | 8 | Received byte |
| miso_i | input | 1 | Serial data in |
| mosi_o | output | 1 | Serial data out |
| sclk_o | output | 1 | Serial clock |
| cs_o | output | 4 | Chip select lines |
| busy_o | output | 1 | Burst in progress (start bit readback) |
| done_o | output | 1 | Transfer-complete pulse |

## Verification
The RX push of one byte and the TX pop of the next byte fall in the same fetch cycle. Multi-byte bursts provoke this in every mode, including the lsb-first mode. The check is that every received byte lands in order while the popped byte appears intact on MOSI. The end of a burst stacks the final push and the completion decision in the same place. This is judged by the push cycle preceding the done pulse, and by done never lasting two cycles. A stall with a partly filled FIFO provokes a pending push together with an empty FIFO. The check is that the push still happens while SCK holds idle.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    localparam int CTRL_W      = 13;
    localparam int CPHA_BIT    = 0;
    localparam int CPOL_BIT    = 1;
    localparam int CSPOL_BIT   = 2;
    localparam int CSSEL_LO    = 4;
    localparam int CS_SEL_W    = 2;
    localparam int CSMAN_BIT   = 6;
    localparam int CSLVL_BIT   = 7;
    localparam int DISCARD_BIT = 8;
    localparam int LSB_BIT     = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SHIFT,
        ST_FIN
    } seq_state_t;

    typedef struct packed {
        logic cpha;
        logic cpol;
        logic lsb_first;
        logic discard;
    } xfer_cfg_t;

    function automatic xfer_cfg_t cfg_decode(input logic [CTRL_W-1:0] w);
        xfer_cfg_t c;
        c.cpha      = w[CPHA_BIT];
        c.cpol      = w[CPOL_BIT];
        c.lsb_first = w[LSB_BIT];
        c.discard   = w[DISCARD_BIT];
        return c;
    endfunction

endpackage

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              bus_en_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [CNT_W-1:0]  burst_cnt_i,
    input  logic [CNT_W-1:0]  xmit_cnt_i,
    input  logic              tx_empty_i,
    input  logic [WORD_W-1:0] tx_data_i,
    input  logic              byte_end_i,
    output logic              tx_pop_o,
    output logic              load_o,
    output logic [WORD_W-1:0] load_data_o,
    output logic              rx_push_o,
    output logic              done_o,
    output logic              busy_o,
    output logic              shifting_o,
    output xfer_cfg_t         cfg_o
);

    seq_state_t       state_q;
    logic [CNT_W-1:0] burst_left_q;
    logic [CNT_W-1:0] tx_left_q;
    logic             pend_push_q;
    xfer_cfg_t        cfg_q;

    logic have_tx;
    logic burst_open;
    logic can_load;

    assign have_tx    = (tx_left_q != '0);
    assign burst_open = (burst_left_q != '0);
    assign can_load   = (state_q == ST_FETCH) && burst_open && !(have_tx && tx_empty_i);

    assign tx_pop_o    = can_load && have_tx;
    assign load_o      = can_load;
    assign load_data_o = have_tx ? tx_data_i : '0;
    assign rx_push_o   = (state_q == ST_FETCH) && pend_push_q && !cfg_q.discard;
    assign done_o      = (state_q == ST_FIN);
    assign busy_o      = (state_q != ST_IDLE);
    assign shifting_o  = (state_q == ST_SHIFT);
    assign cfg_o       = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            burst_left_q <= '0;
            tx_left_q    <= '0;
            pend_push_q  <= 1'b0;
            cfg_q        <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i && bus_en_i) begin
                        cfg_q        <= cfg_decode(ctrl_i);
                        burst_left_q <= burst_cnt_i;
                        tx_left_q    <= xmit_cnt_i;
                        pend_push_q  <= 1'b0;
                        state_q      <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    pend_push_q <= 1'b0;
                    if (!burst_open) begin
                        state_q <= ST_FIN;
                    end else if (can_load) begin
                        state_q <= ST_SHIFT;
                        if (have_tx) begin
                            tx_left_q <= tx_left_q - CNT_W'(1);
                        end
                    end
                end
                ST_SHIFT: begin
                    if (byte_end_i) begin
                        burst_left_q <= burst_left_q - CNT_W'(1);
                        pend_push_q  <= 1'b1;
                        state_q      <= ST_FETCH;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] load_data_i,
    input  logic              tick_i,
    input  logic              cpha_i,
    input  logic              cpol_i,
    input  logic              lsb_first_i,
    input  logic              busy_i,
    input  logic              bus_en_i,
    input  logic              idle_cpol_i,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic              sclk_o,
    output logic [WORD_W-1:0] rx_byte_o,
    output logic              byte_end_o
);

    localparam int EDGES = 2 * WORD_W;
    localparam int EW    = $clog2(EDGES);

    logic [WORD_W-1:0] tx_sh_q;
    logic [WORD_W-1:0] rx_sh_q;
    logic [EW-1:0]     edge_q;
    logic              sck_lvl_q;

    logic sample_now;
    logic shift_now;

    assign sample_now = tick_i && (edge_q[0] == cpha_i);
    assign shift_now  = tick_i && (edge_q[0] != cpha_i) && !(cpha_i && (edge_q == '0));
    assign byte_end_o = tick_i && (edge_q == EW'(EDGES - 1));

    assign mosi_o    = lsb_first_i ? tx_sh_q[0] : tx_sh_q[WORD_W-1];
    assign rx_byte_o = rx_sh_q;

    always_comb begin
        if (!bus_en_i) begin
            sclk_o = 1'b0;
        end else if (busy_i) begin
            sclk_o = cpol_i ^ sck_lvl_q;
        end else begin
            sclk_o = idle_cpol_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh_q   <= '0;
            rx_sh_q   <= '0;
            edge_q    <= '0;
            sck_lvl_q <= 1'b0;
        end else if (load_i) begin
            tx_sh_q   <= load_data_i;
            edge_q    <= '0;
            sck_lvl_q <= 1'b0;
        end else if (tick_i) begin
            edge_q    <= edge_q + EW'(1);
            sck_lvl_q <= ~sck_lvl_q;
            if (sample_now) begin
                if (lsb_first_i) begin
                    rx_sh_q <= {miso_i, rx_sh_q[WORD_W-1:1]};
                end else begin
                    rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
                end
            end
            if (shift_now) begin
                if (lsb_first_i) begin
                    tx_sh_q <= {1'b0, tx_sh_q[WORD_W-1:1]};
                end else begin
                    tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_seq_cs.sv
module spi_seq_cs
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic [CS_SEL_W-1:0] sel_i,
    input  logic                pol_i,
    input  logic                manual_i,
    input  logic                level_i,
    input  logic                busy_i,
    output logic [NUM_CS-1:0]   cs_o
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        logic picked;
        assign picked = (sel_i == CS_SEL_W'(i));
        always_comb begin
            if (!picked) begin
                cs_o[i] = pol_i;
            end else if (manual_i) begin
                cs_o[i] = level_i;
            end else begin
                cs_o[i] = busy_i ? ~pol_i : pol_i;
            end
        end
    end

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
    import spi_seq_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int WORD_W = 8,
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              start_i,
    input  logic              bus_en_i,
    input  logic [CNT_W-1:0]  burst_cnt_i,
    input  logic [CNT_W-1:0]  xmit_cnt_i,
    input  logic              sck_tick_i,
    input  logic              tx_empty_i,
    input  logic [WORD_W-1:0] tx_data_i,
    output logic              tx_pop_o,
    output logic              rx_push_o,
    output logic [WORD_W-1:0] rx_data_o,
    input  logic              miso_i,
    output logic              mosi_o,
    output logic              sclk_o,
    output logic [NUM_CS-1:0] cs_o,
    output logic              busy_o,
    output logic              done_o
);

    logic              load;
    logic [WORD_W-1:0] load_data;
    logic              shifting;
    logic              byte_end;
    logic              shift_tick;
    xfer_cfg_t         cfg_q;
    logic              cfg_discard;
    logic              ctrl_unused;

    assign shift_tick  = shifting && sck_tick_i && bus_en_i;
    assign cfg_discard = cfg_q.discard;
    assign ctrl_unused = ^{ctrl_i[3], ctrl_i[11:9]};

    spi_seq_ctrl #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .bus_en_i    (bus_en_i),
        .ctrl_i      (ctrl_i),
        .burst_cnt_i (burst_cnt_i),
        .xmit_cnt_i  (xmit_cnt_i),
        .tx_empty_i  (tx_empty_i),
        .tx_data_i   (tx_data_i),
        .byte_end_i  (byte_end),
        .tx_pop_o    (tx_pop_o),
        .load_o      (load),
        .load_data_o (load_data),
        .rx_push_o   (rx_push_o),
        .done_o      (done_o),
        .busy_o      (busy_o),
        .shifting_o  (shifting),
        .cfg_o       (cfg_q)
    );

    spi_seq_shift #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load),
        .load_data_i (load_data),
        .tick_i      (shift_tick),
        .cpha_i      (cfg_q.cpha),
        .cpol_i      (cfg_q.cpol),
        .lsb_first_i (cfg_q.lsb_first),
        .busy_i      (busy_o),
        .bus_en_i    (bus_en_i),
        .idle_cpol_i (ctrl_i[CPOL_BIT]),
        .miso_i      (miso_i),
        .mosi_o      (mosi_o),
        .sclk_o      (sclk_o),
        .rx_byte_o   (rx_data_o),
        .byte_end_o  (byte_end)
    );

    spi_seq_cs #(.NUM_CS(NUM_CS)) u_cs (
        .sel_i    (ctrl_i[CSSEL_LO +: CS_SEL_W]),
        .pol_i    (ctrl_i[CSPOL_BIT]),
        .manual_i (ctrl_i[CSMAN_BIT]),
        .level_i  (ctrl_i[CSLVL_BIT]),
        .busy_i   (busy_o),
        .cs_o     (cs_o)
    );

endmodule

// File: rtl/spi_seq_chk.sv
module spi_seq_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              bus_en_i,
    input logic              cs_pol_i,
    input logic              tx_empty_i,
    input logic              tx_pop_o,
    input logic              rx_push_o,
    input logic [NUM_CS-1:0] cs_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              cfg_discard
);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_ends_busy_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    assert_discard_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cfg_discard) |-> !rx_push_o);

    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
        tx_pop_o |-> !tx_empty_i);

    assert_start_gated_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> ($past(bus_en_i) && $past(start_i)));

    assert_cs_single_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_o ^ {NUM_CS{cs_pol_i}}));

    assert_push_in_burst_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_push_o || tx_pop_o) |-> busy_o);

endmodule

bind spi_xfer_seq spi_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .bus_en_i    (bus_en_i),
    .cs_pol_i    (ctrl_i[2]),
    .tx_empty_i  (tx_empty_i),
    .tx_pop_o    (tx_pop_o),
    .rx_push_o   (rx_push_o),
    .cs_o        (cs_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cfg_discard (cfg_discard)
);

// File: tb/spi_xfer_seq_tb.sv
`timescale 1ns/1ps
module spi_xfer_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] ctrl = '0;
    logic        start = 1'b0;
    logic        bus_en = 1'b0;
    logic [23:0] burst = '0;
    logic [23:0] xmit = '0;
    logic        tick = 1'b0;
    logic        tx_empty;
    logic [7:0]  tx_data;
    logic        tx_pop;
    logic        rx_push;
    logic [7:0]  rx_data;
    logic        miso;
    logic        mosi;
    logic        sclk;
    logic [3:0]  cs;
    logic        busy;
    logic        done;

    always #10 clk = ~clk;

    spi_xfer_seq u_dut (
        .clk(clk), .rst(rst), .ctrl_i(ctrl), .start_i(start), .bus_en_i(bus_en),
        .burst_cnt_i(burst), .xmit_cnt_i(xmit), .sck_tick_i(tick),
        .tx_empty_i(tx_empty), .tx_data_i(tx_data), .tx_pop_o(tx_pop),
        .rx_push_o(rx_push), .rx_data_o(rx_data), .miso_i(miso), .mosi_o(mosi),
        .sclk_o(sclk), .cs_o(cs), .busy_o(busy), .done_o(done)
    );

    int checks = 0;
    int fails  = 0;

    logic [7:0] txq [0:15];
    int tx_wr = 0;
    int tx_rd = 0;
    logic [7:0] slv [0:15];
    logic [7:0] wmem [0:15];
    logic [7:0] rmem [0:15];
    logic [7:0] wsh = '0;
    int scnt = 0, npush = 0, ndone = 0, nedge = 0, dbl = 0;
    int cyc = 0, push_cyc = 0, done_cyc = 0;
    logic prev_sclk = 1'b0, prev_done = 1'b0;
    logic cur_cpol = 1'b0, cur_cpha = 1'b0;

    assign tx_empty = (tx_rd == tx_wr);
    assign tx_data  = txq[tx_rd & 15];
    always_comb miso = slv[(scnt >> 3) & 15][7 - (scnt & 7)];

    always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

    always @(negedge clk) begin
        if (rst) tick = 1'b0; else tick = ~tick;
    end

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (busy && sclk !== prev_sclk) begin
            logic lead;
            nedge = nedge + 1;
            lead = (sclk != cur_cpol);
            if ((lead && !cur_cpha) || (!lead && cur_cpha)) begin
                if ((scnt & 7) == 7) wmem[(scnt >> 3) & 15] = {wsh[6:0], mosi};
                wsh  = {wsh[6:0], mosi};
                scnt = scnt + 1;
            end
        end
        prev_sclk = sclk;
        if (rx_push) begin
            rmem[npush & 15] = rx_data;
            npush = npush + 1;
            push_cyc = cyc;
        end
        if (done) begin
            ndone = ndone + 1;
            done_cyc = cyc;
        end
        if (done && prev_done) dbl = dbl + 1;
        prev_done = done;
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7 - i];
        return r;
    endfunction

    function automatic logic [12:0] mk(input logic cpol, input logic cpha, input logic lsb,
                                       input logic disc, input logic [1:0] sel, input logic spol,
                                       input logic man, input logic lvl);
        logic [12:0] w;
        w = '0;
        w[0] = cpha; w[1] = cpol; w[2] = spol; w[5:4] = sel;
        w[6] = man; w[7] = lvl; w[8] = disc; w[12] = lsb;
        return w;
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic prep(input logic [12:0] c, input int b, input int x);
        @(posedge clk);
        tx_wr = 0; tx_rd = 0; scnt = 0; npush = 0; ndone = 0; nedge = 0; dbl = 0;
        @(negedge clk);
        ctrl = c; burst = 24'(b); xmit = 24'(x);
        cur_cpol = c[1]; cur_cpha = c[0];
    endtask

    task automatic push_tx(input logic [7:0] b);
        txq[tx_wr & 15] = b;
        tx_wr = tx_wr + 1;
    endtask

    task automatic fire();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (ndone == 0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(ndone == 1, "R9 done count", ndone, 1);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 reset busy", busy, 0);
        chk(done == 1'b0, "R9 reset done", done, 0);
        chk(sclk == 1'b0, "R10 reset sclk", sclk, 0);
        chk(cs == 4'h0, "R6 reset cs", cs, 0);
    endtask

    task automatic t_bus_off();
        prep(mk(1, 0, 0, 0, 0, 0, 0, 0), 1, 1);
        bus_en = 1'b0;
        push_tx(8'h11);
        fire();
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R10 start ignored busy", busy, 0);
        chk(sclk == 1'b0, "R10 sclk held low", sclk, 0);
        chk(tx_rd == 0, "R10 no pop", tx_rd, 0);
        bus_en = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1, "R2 idle level cpol=1", sclk, 1);
    endtask

    task automatic t_mode0();
        prep(mk(0, 0, 0, 0, 2'd0, 0, 0, 0), 3, 3);
        push_tx(8'hA5); push_tx(8'h3C); push_tx(8'h81);
        slv[0] = 8'h5A; slv[1] = 8'hC3; slv[2] = 8'h0F;
        fire();
        repeat (6) @(negedge clk);
        chk(busy == 1'b1, "R1 busy in burst", busy, 1);
        chk(cs == 4'b0001, "R6 auto cs active high", cs, 4'b0001);
        wait_done();
        chk(wmem[0] == 8'hA5, "R2 mode0 mosi b0", wmem[0], 8'hA5);
        chk(wmem[1] == 8'h3C, "R2 mode0 mosi b1", wmem[1], 8'h3C);
        chk(wmem[2] == 8'h81, "R2 mode0 mosi b2", wmem[2], 8'h81);
        chk(rmem[0] == 8'h5A, "R4 mode0 rx b0", rmem[0], 8'h5A);
        chk(rmem[1] == 8'hC3, "R4 mode0 rx b1", rmem[1], 8'hC3);
        chk(rmem[2] == 8'h0F, "R4 mode0 rx b2", rmem[2], 8'h0F);
        chk(npush == 3, "R4 push count", npush, 3);
        chk(nedge == 48, "R2 edge count", nedge, 48);
        chk(sclk == 1'b0, "R2 sclk idle after", sclk, 0);
        chk(dbl == 0, "R9 done single cycle", dbl, 0);
        chk(done_cyc > push_cyc, "R9 done after last push", done_cyc, push_cyc + 1);
        chk(busy == 1'b0, "R1 busy cleared", busy, 0);
        chk(cs == 4'b0000, "R6 cs released", cs, 0);
    endtask

    task automatic t_mode3_lsb();
        prep(mk(1, 1, 1, 0, 2'd0, 0, 0, 0), 2, 2);
        push_tx(8'h12); push_tx(8'hF0);
        slv[0] = 8'h96; slv[1] = 8'h01;
        fire();
        wait_done();
        chk(wmem[0] == rev8(8'h12), "R3 lsb mosi b0", wmem[0], rev8(8'h12));
        chk(wmem[1] == rev8(8'hF0), "R3 lsb mosi b1", wmem[1], rev8(8'hF0));
        chk(rmem[0] == rev8(8'h96), "R3 lsb rx b0", rmem[0], rev8(8'h96));
        chk(rmem[1] == rev8(8'h01), "R3 lsb rx b1", rmem[1], rev8(8'h01));
        chk(sclk == 1'b1, "R2 mode3 idle high", sclk, 1);
    endtask

    task automatic t_mode(input logic cpol, input logic cpha);
        prep(mk(cpol, cpha, 0, 0, 2'd0, 0, 0, 0), 1, 1);
        push_tx(8'hC9);
        slv[0] = 8'h3E;
        fire();
        wait_done();
        chk(wmem[0] == 8'hC9, "R2 mode mosi", wmem[0], 8'hC9);
        chk(rmem[0] == 8'h3E, "R2 mode rx", rmem[0], 8'h3E);
        chk(nedge == 16, "R2 mode edges", nedge, 16);
    endtask

    task automatic t_filler();
        prep(mk(0, 0, 0, 0, 2'd0, 0, 0, 0), 4, 2);
        push_tx(8'h77); push_tx(8'hEE); push_tx(8'h55);
        for (int i = 0; i < 4; i++) slv[i] = 8'(i + 1);
        fire();
        wait_done();
        chk(wmem[0] == 8'h77, "R4 tx b0", wmem[0], 8'h77);
        chk(wmem[1] == 8'hEE, "R4 tx b1", wmem[1], 8'hEE);
        chk(wmem[2] == 8'h00, "R4 filler b2", wmem[2], 0);
        chk(wmem[3] == 8'h00, "R4 filler b3", wmem[3], 0);
        chk(tx_rd == 2, "R4 pops limited", tx_rd, 2);
        chk(npush == 4, "R4 all bytes pushed", npush, 4);
        chk(rmem[3] == 8'h04, "R4 rx last", rmem[3], 4);
    endtask

    task automatic t_discard();
        prep(mk(0, 0, 0, 1, 2'd0, 0, 0, 0), 2, 2);
        push_tx(8'h5C); push_tx(8'hC5);
        fire();
        wait_done();
        chk(npush == 0, "R5 no push on discard", npush, 0);
        chk(wmem[1] == 8'hC5, "R5 mosi unaffected", wmem[1], 8'hC5);
    endtask

    task automatic t_cs_auto();
        prep(mk(0, 0, 0, 0, 2'd2, 1, 0, 0), 1, 1);
        push_tx(8'h01);
        @(negedge clk);
        chk(cs == 4'hF, "R6 idle cs active-low", cs, 4'hF);
        fire();
        repeat (6) @(negedge clk);
        chk(cs == 4'b1011, "R6 selected line low", cs, 4'b1011);
        wait_done();
        chk(cs == 4'hF, "R6 released high", cs, 4'hF);
    endtask

    task automatic t_cs_manual();
        @(negedge clk) ctrl = mk(0, 0, 0, 0, 2'd1, 1, 1, 0);
        @(negedge clk);
        chk(cs == 4'b1101, "R7 manual level 0", cs, 4'b1101);
        @(negedge clk) ctrl = mk(0, 0, 0, 0, 2'd1, 1, 1, 1);
        @(negedge clk);
        chk(cs == 4'b1111, "R7 manual level 1", cs, 4'b1111);
    endtask

    task automatic t_stall();
        prep(mk(0, 0, 0, 0, 2'd0, 0, 0, 0), 2, 2);
        push_tx(8'hA1);
        slv[0] = 8'h10; slv[1] = 8'h20;
        fire();
        repeat (200) @(negedge clk);
        chk(busy == 1'b1, "R8 still busy", busy, 1);
        chk(nedge == 16, "R8 no edges while stalled", nedge, 16);
        chk(sclk == 1'b0, "R8 sclk idle", sclk, 0);
        chk(npush == 1, "R8 first byte pushed", npush, 1);
        chk(tx_rd == 1, "R8 single pop", tx_rd, 1);
        push_tx(8'hB2);
        wait_done();
        chk(wmem[1] == 8'hB2, "R8 resumed byte", wmem[1], 8'hB2);
        chk(rmem[1] == 8'h20, "R8 resumed rx", rmem[1], 8'h20);
    endtask

    task automatic t_zero();
        prep(mk(0, 0, 0, 0, 2'd0, 0, 0, 0), 0, 5);
        push_tx(8'h99);
        fire();
        wait_done();
        chk(nedge == 0, "R11 no edges", nedge, 0);
        chk(tx_rd == 0, "R11 no pop", tx_rd, 0);
        chk(npush == 0, "R11 no push", npush, 0);
        chk(busy == 1'b0, "R11 idle after", busy, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_bus_off();
        t_mode0();
        t_mode3_lsb();
        t_mode(0, 1);
        t_mode(1, 0);
        t_filler();
        t_discard();
        t_cs_auto();
        t_cs_manual();
        t_stall();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule